// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between a serial-bus protocol engine and a 256-byte storage array. When the engine decodes a write command it opens a page with a word address, then passes each received data byte with a one-cycle strobe. The block keeps those bytes in a 16-entry buffer indexed by the low address bits. The pointer advances only within the current 16-byte page, so a long burst wraps to the start of the same page and overwrites bytes that came earlier.

Nothing reaches the array until the engine reports the stop condition with a commit strobe. The block then raises busy for a fixed number of clocks set by a parameter, and scans the buffer in ascending offset order. Each offset that was loaded is written once through a simple write port. While the write-protect level is high, locations in the upper half of the array are skipped. The busy window keeps its full length even when every byte was skipped. While busy is high, the engine withholds acknowledges, and the block ignores all of its strobes.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy and memWe are low and no byte is loaded.
- R2: The first byte after a page start lands at wordAddr[3:0], and each further byte at the next offset. A loaded byte at offset k is written to address {wordAddr[7:4], k}.
- R3: The offset wraps from 15 to 0 and address bits [7:4] stay unchanged, so a burst past the page end refills the start of the same page.
- R4: When more than 16 bytes arrive before commit, each offset holds the last byte received for it. The page is written with 16 writes.
- R5: memWe never goes high before a commit is accepted. It is high only while busy is high.
- R6: With wpLevel high, no write reaches an address with bit 7 set, while addresses 0x00 to 0x7F are still written. With wpLevel low, every address is written.
- R7: An accepted commit holds busy high for exactly WRITE_CYCLES clocks, even when protection skipped every write.
- R8: During the commit, each loaded offset is written exactly once, in ascending offset order, and unloaded offsets are not written. The loaded set is empty once busy falls.
- R9: A commit with no bytes loaded does not raise busy and writes nothing.
- R10: While busy is high, pageStart, byteValid and commit have no effect.
- R11: A page start drops any bytes loaded but not yet committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageStart | input | 1 | One-cycle strobe that opens a page at wordAddr |
| wordAddr | input | 8 | Word address captured with pageStart |
| byteValid | input | 1 | One-cycle strobe that loads byteData |
| byteData | input | 8 | Data byte to buffer |
| commit | input | 1 | One-cycle strobe from the stop condition |
| wpLevel | input | 1 | Write-protect level for the upper half of the array |
| busy | output | 1 | High during the timed write cycle |
| memWe | output | 1 | Array write enable |
| memAddr | output | 8 | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
The assertions assume that strobes are one clock wide. They also assume that wpLevel stays constant for the whole busy window, since protection is sampled when each write is issued. The bench drives every strobe for a single cycle on the falling edge and changes wpLevel only while busy is low. It fires strobes during busy only in the scenario that checks they are ignored.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic openPage;   // capture page base and offset, drop loaded bytes
    logic loadByte;   // store byte at current offset, advance offset
    logic scanEn;     // scan slot active, offset given by scanIdx
    logic clearMask;  // last busy cycle: forget loaded offsets
  } pwbStrobes_t;

endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageStart,
  input  logic              byteValid,
  input  logic              commit,
  input  logic              anyLoaded,
  output pwbStrobes_t       strobes,
  output logic [PAGE_W-1:0] scanIdx,
  output logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  typedef enum logic {ST_IDLE, ST_WRITE} pwbState_e;

  pwbState_e  state;
  logic [CNT_W-1:0] cycleCnt;
  logic       lastCycle;
  logic       startWrite;

  assign lastCycle  = (state == ST_WRITE) && (cycleCnt == CNT_W'(WRITE_CYCLES - 1));
  assign startWrite = (state == ST_IDLE) && commit && anyLoaded;
  assign busy       = (state == ST_WRITE);
  assign scanIdx    = cycleCnt[PAGE_W-1:0];

  always_comb begin
    strobes           = '0;
    strobes.openPage  = (state == ST_IDLE) && pageStart && !commit;
    strobes.loadByte  = (state == ST_IDLE) && byteValid && !pageStart && !commit;
    strobes.scanEn    = (state == ST_WRITE) && (cycleCnt < CNT_W'(PAGE_BYTES));
    strobes.clearMask = lastCycle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cycleCnt <= '0;
          if (startWrite) state <= ST_WRITE;
        end
        ST_WRITE: begin
          if (lastCycle) begin
            state    <= ST_IDLE;
            cycleCnt <= '0;
          end else begin
            cycleCnt <= cycleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: a write cycle starts only from a commit with bytes pending
  p_busy_needs_bytes_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commit && anyLoaded));

  // R10: no buffer activity is requested during the write cycle
  p_quiet_when_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobes.openPage || strobes.loadByte));

  // R7: busy falls only after the full window
  p_full_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(cycleCnt) == CNT_W'(WRITE_CYCLES - 1)));

endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobes_t       strobes,
  input  logic [PAGE_W-1:0] scanIdx,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic              wpLevel,
  output logic              anyLoaded,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;

  logic [BASE_W-1:0] pageBase;
  logic [PAGE_W-1:0] wrPtr;
  logic [DATA_W-1:0] slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;
  logic              upperLocked;

  // Page base and in-page pointer; only the low bits advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase <= '0;
      wrPtr    <= '0;
    end else if (strobes.openPage) begin
      pageBase <= wordAddr[ADDR_W-1:PAGE_W];
      wrPtr    <= wordAddr[PAGE_W-1:0];
    end else if (strobes.loadByte) begin
      wrPtr    <= wrPtr + 1'b1;
    end
  end

  // One slot per page offset
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = strobes.loadByte && (wrPtr == PAGE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[g] <= '0;
        loaded[g]   <= 1'b0;
      end else begin
        if (hit) slotData[g] <= byteData;
        if (strobes.openPage || strobes.clearMask) loaded[g] <= 1'b0;
        else if (hit)                              loaded[g] <= 1'b1;
      end
    end
  end

  assign anyLoaded   = |loaded;
  assign memAddr     = {pageBase, scanIdx};
  assign memWdata    = slotData[scanIdx];
  assign upperLocked = wpLevel && memAddr[ADDR_W-1];
  assign memWe       = strobes.scanEn && loaded[scanIdx] && !upperLocked;

  // R5: writes appear only inside the scan slots of a write cycle
  p_write_in_scan_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> strobes.scanEn);

  // R6: protected upper half is never written
  p_upper_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && wpLevel) |-> !memAddr[ADDR_W-1]);

  // R8: loaded set is empty after the write cycle ends
  p_mask_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearMask |=> !anyLoaded);

  // R11: opening a page drops pending bytes
  p_open_drops_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.openPage |=> !anyLoaded);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageStart,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commit,
  input  logic              wpLevel,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  pwbStrobes_t       strobes;
  logic [PAGE_W-1:0] scanIdx;
  logic              anyLoaded;

  pwb_ctrl #(
    .PAGE_W      (PAGE_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pageStart(pageStart),
    .byteValid(byteValid),
    .commit   (commit),
    .anyLoaded(anyLoaded),
    .strobes  (strobes),
    .scanIdx  (scanIdx),
    .busy     (busy)
  );

  pwb_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .scanIdx  (scanIdx),
    .wordAddr (wordAddr),
    .byteData (byteData),
    .wpLevel  (wpLevel),
    .anyLoaded(anyLoaded),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: tb/test_page_write_buffer.sv
module test_page_write_buffer;

  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pageStart = 1'b0;
  logic [7:0] wordAddr = '0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       commit = 1'b0;
  logic       wpLevel = 1'b0;
  logic       busy, memWe;
  logic [7:0] memAddr, memWdata;

  int checks = 0;
  int fails  = 0;

  // write log filled at every clock edge with memWe high
  logic [7:0] logAddr [1024];
  logic [7:0] logData [1024];
  int         logN = 0;

  always #4 clk = ~clk;

  page_write_buffer #(.WRITE_CYCLES(WC)) i_page_write_buffer (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .wordAddr(wordAddr),
    .byteValid(byteValid), .byteData(byteData), .commit(commit),
    .wpLevel(wpLevel), .busy(busy), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata)
  );

  always @(posedge clk) begin
    if (memWe && logN < 1024) begin
      logAddr[logN] <= memAddr;
      logData[logN] <= memWdata;
      logN <= logN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic openPage(input logic [7:0] a);
    @(negedge clk); wordAddr = a; pageStart = 1'b1;
    @(negedge clk); pageStart = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); byteData = d; byteValid = 1'b1;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic runCommit(output int busyLen);
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    busyLen = 0;
    while (busy && busyLen < 10 * WC) begin
      busyLen++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic findWrite(input int from, input logic [7:0] a, output int n, output int d);
    n = 0; d = -1;
    for (int i = from; i < logN; i++)
      if (logAddr[i] == a) begin n++; d = logData[i]; end
  endtask

  task automatic tReset;
    int len, base;
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(memWe == 1'b0, "R1 memWe after reset", memWe, 0);
    base = logN;
    runCommit(len);
    check(len == 0, "R1/R9 empty commit busy", len, 0);
    check(logN == base, "R9 empty commit writes", logN - base, 0);
  endtask

  task automatic tBasic;
    int len, base, n, d;
    base = logN;
    openPage(8'h23);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3);
    repeat (3) @(negedge clk);
    check(logN == base, "R5 no write before commit", logN - base, 0);
    runCommit(len);
    check(len == WC, "R7 busy length", len, WC);
    check(logN - base == 3, "R8 write count", logN - base, 3);
    for (int k = 0; k < 3; k++) begin
      findWrite(base, 8'(8'h23 + k), n, d);
      check(n == 1 && d == 8'hA1 + k, "R2 byte placement", d, 8'hA1 + k);
    end
    check(busy == 1'b0 && memWe == 1'b0, "R5 idle after cycle", memWe, 0);
  endtask

  task automatic tWrap;
    int len, base;
    base = logN;
    openPage(8'h3E);
    sendByte(8'h11); sendByte(8'h12); sendByte(8'h13); sendByte(8'h14);
    runCommit(len);
    check(logN - base == 4, "R3 wrap write count", logN - base, 4);
    // ascending offset order: 0,1,E,F
    check(logAddr[base]   == 8'h30 && logData[base]   == 8'h13, "R3/R8 wrap off0", logAddr[base], 8'h30);
    check(logAddr[base+1] == 8'h31 && logData[base+1] == 8'h14, "R3/R8 wrap off1", logAddr[base+1], 8'h31);
    check(logAddr[base+2] == 8'h3E && logData[base+2] == 8'h11, "R3/R8 wrap offE", logAddr[base+2], 8'h3E);
    check(logAddr[base+3] == 8'h3F && logData[base+3] == 8'h12, "R3/R8 wrap offF", logAddr[base+3], 8'h3F);
  endtask

  task automatic tOverwrite;
    int len, base, n, d, bad;
    base = logN; bad = 0;
    openPage(8'h50);
    for (int i = 0; i < 18; i++) sendByte(8'(8'h10 + i));
    runCommit(len);
    check(logN - base == 16, "R4 page write count", logN - base, 16);
    for (int k = 0; k < 16; k++) begin
      findWrite(base, 8'(8'h50 + k), n, d);
      if (n != 1 || d != ((k < 2) ? 8'h20 + k : 8'h10 + k)) bad++;
    end
    check(bad == 0, "R4 last byte per offset", bad, 0);
  endtask

  task automatic tProtect;
    int len, base, n, d;
    wpLevel = 1'b1;
    base = logN;
    openPage(8'h90);
    sendByte(8'h5A); sendByte(8'h5B);
    runCommit(len);
    check(logN == base, "R6 upper half locked", logN - base, 0);
    check(len == WC, "R7 full busy when all skipped", len, WC);
    base = logN;
    openPage(8'h10);
    sendByte(8'h77);
    runCommit(len);
    findWrite(base, 8'h10, n, d);
    check(n == 1 && d == 8'h77, "R6 lower half open", d, 8'h77);
    wpLevel = 1'b0;
    base = logN;
    openPage(8'hF0);
    sendByte(8'h99);
    runCommit(len);
    findWrite(base, 8'hF0, n, d);
    check(n == 1 && d == 8'h99, "R6 upper writable unprotected", d, 8'h99);
  endtask

  task automatic tBusyIgnore;
    int len, base, n, d;
    base = logN;
    openPage(8'h40);
    sendByte(8'h01);
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    // strobes during busy
    @(negedge clk); wordAddr = 8'h48; pageStart = 1'b1;
    @(negedge clk); pageStart = 1'b0; byteData = 8'hEE; byteValid = 1'b1;
    @(negedge clk); byteValid = 1'b0; commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    findWrite(base, 8'h40, n, d);
    check(n == 1 && d == 8'h01, "R10 commit unaffected", d, 8'h01);
    check(logN - base == 1, "R10 no extra writes", logN - base, 1);
    base = logN;
    runCommit(len);
    check(len == 0, "R10/R8 nothing loaded during busy", len, 0);
    check(logN == base, "R8 mask cleared", logN - base, 0);
  endtask

  task automatic tDiscard;
    int len, base, n, d;
    base = logN;
    openPage(8'h60);
    sendByte(8'hC1); sendByte(8'hC2);
    openPage(8'h70);
    sendByte(8'hD1);
    runCommit(len);
    check(logN - base == 1, "R11 dropped bytes not written", logN - base, 1);
    findWrite(base, 8'h70, n, d);
    check(n == 1 && d == 8'hD1, "R11 new page byte", d, 8'hD1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tWrap();
    tOverwrite();
    tProtect();
    tBusyIgnore();
    tDiscard();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule